// File: doc/BRIEF.md
# Sixteen-Input Scanning Converter Sequencer with Window Watchdog

This block is the digital controller of a 10-bit successive-approximation converter with sixteen analog inputs. Software picks a first channel and writes a start command. The sequencer then steps upward through the inputs to the last one. It drives the analog multiplexer select, and for each input it times a sampling phase and then a conversion phase. Both phases are counted in ticks of a converter clock, which is made by dividing the system clock. At the end of each conversion it takes the digital result from the converter model and stores it left-justified as an upper and a lower byte.

Two adjacent channels, chosen by software, are compared against a shared high/low threshold window. An out-of-window result sets a sticky flag. Completion of a scan sets its own sticky flag. A single interrupt line combines these flags through two enable bits. In continuous mode the scan restarts from the first channel after the last channel. Reading a result's upper byte captures its lower bits, so a byte pair read in two accesses always belongs to one conversion.

Register map (6-bit byte address): 0x00 SCANCFG (bits 7:4 first channel, bits 3:0 watchdog base channel), 0x01 RUNCTL (bits 7:5 clock select, bit 4 end-of-scan interrupt enable, bit 3 watchdog interrupt enable, bit 1 continuous, bit 0 start on write / busy on read), 0x02 FLAGS, 0x04/0x05 high threshold upper/lower, 0x06/0x07 low threshold upper/lower, 0x20 + 2·ch result upper, 0x21 + 2·ch result lower. Read data appears on the clock edge after the read strobe.

Top module: `adcseq_top`

## Requirements
- R1: After reset all control bits, FLAGS and results read 0x00, the high threshold reads 0xFF/0xC0, the low threshold reads 0x00/0x00, and irq and sample_en are low.
- R2: RUNCTL bits 7:5 values 0..7 select a converter-clock period of 2, 4, 6, 8, 12, 16, 24 or 32 system clocks, counted from the start write.
- R3: Each channel is sampled for 8 converter-clock ticks (sample_en high, mux_sel showing the channel) and then converted for 20 ticks, so the next channel appears 28 ticks after the previous one.
- R4: Writing RUNCTL with bit 0 set while idle scans from SCANCFG bits 7:4 upward to channel 15. After the last conversion FLAGS bit 0 (end of scan) is set and FLAGS bit 7 (busy) clears in single mode. Channels below the first one keep their old results.
- R5: With RUNCTL bit 1 set the scan restarts at the first channel after channel 15 and stays busy. Clearing the bit lets the current scan finish and then stop.
- R6: A result v is read at 0x20+2·ch as v[9:2] and at 0x21+2·ch as {v[1:0],000000}, so zero reads 0x00/0x00 and full scale reads 0xFF/0xC0.
- R7: Threshold lower bytes store only bits 7:6 and read the other bits as 0. Threshold upper bytes store all 8 bits.
- R8: With watchdog base b = SCANCFG bits 3:0, a result of channel b sets FLAGS bit 1 and a result of channel b+1 (mod 16) sets FLAGS bit 2 when the result is above the high threshold or below the low threshold. Results inside the window, and results of any other channel, set neither bit.
- R9: FLAGS bits 0..2 stay set until software writes 1 to them. Writing 0 has no effect, and a new event in the same cycle as a clear wins.
- R10: irq is high when (FLAGS bit 0 and RUNCTL bit 4) or (FLAGS bit 1 or 2, and RUNCTL bit 3).
- R11: A read of a result upper byte captures that result's low bits. The next lower-byte read returns the captured bits even if a newer conversion of that channel has completed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| mux_sel | output | 4 | Analog multiplexer channel select |
| sample_en | output | 1 | High during the sampling phase |
| conv_data | input | 10 | Result from the converter, taken at the last conversion tick |
| irq | output | 1 | Combined interrupt request |

## Verification
The converter model returns a different value for each channel: values inside the window, values above and below it, zero, full scale, and values whose two low bits differ from scan to scan. A wrong channel order, a truncated scan, a misplaced bit, or a watchdog slot hooked to the wrong channel therefore shows up as a wrong byte. Scans are run with three divider settings and with first channels 3, 14 and 15. The cycle just before and the cycle of the end-of-scan interrupt are both checked, which separates correct phase lengths from lengths that are off by one tick. A continuous scan is stopped by clearing its mode bit. One channel is reconverted between the two halves of a split read to show that the captured lower bits survive.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_CONVERT = 2'd2
  } phase_e;

  localparam logic [5:0] A_SCANCFG = 6'h00;
  localparam logic [5:0] A_RUNCTL  = 6'h01;
  localparam logic [5:0] A_FLAGS   = 6'h02;
  localparam logic [5:0] A_THI_U   = 6'h04;
  localparam logic [5:0] A_THI_L   = 6'h05;
  localparam logic [5:0] A_TLO_U   = 6'h06;
  localparam logic [5:0] A_TLO_L   = 6'h07;

  function automatic logic [5:0] div_of(input logic [2:0] sel);
    case (sel)
      3'd0:    div_of = 6'd2;
      3'd1:    div_of = 6'd4;
      3'd2:    div_of = 6'd6;
      3'd3:    div_of = 6'd8;
      3'd4:    div_of = 6'd12;
      3'd5:    div_of = 6'd16;
      3'd6:    div_of = 6'd24;
      default: div_of = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/adcseq_clkdiv.sv
module adcseq_clkdiv
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [5:0] cnt_q, cnt_n, last;

  assign last = div_of(sel) - 6'd1;
  assign tick = en && (cnt_q == last);

  always_comb begin
    if (!en || cnt_q == last) cnt_n = '0;
    else                      cnt_n = cnt_q + 6'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/adcseq_scan.sv
module adcseq_scan
  import adcseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int RES_W    = 10,
  parameter int SAMP_CYC = 8,
  parameter int CONV_CYC = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     start,
  input  logic [$clog2(NCH)-1:0]   start_ch,
  input  logic                     cont,
  input  logic [RES_W-1:0]         conv_data,
  output logic                     busy,
  output logic                     sampling,
  output logic [$clog2(NCH)-1:0]   ch,
  output logic                     res_valid,
  output logic [RES_W-1:0]         res_data,
  output logic                     done
);
  localparam int CH_W  = $clog2(NCH);
  localparam int MAXC  = (CONV_CYC > SAMP_CYC) ? CONV_CYC : SAMP_CYC;
  localparam int CNT_W = $clog2(MAXC);
  localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);
  localparam logic [CH_W-1:0]  CH_LAST   = CH_W'(NCH - 1);

  phase_e           ph_q, ph_n;
  logic [CH_W-1:0]  ch_q, ch_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    ph_n      = ph_q;
    ch_n      = ch_q;
    cnt_n     = cnt_q;
    res_valid = 1'b0;
    done      = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_n  = PH_SAMPLE;
          ch_n  = start_ch;
          cnt_n = '0;
        end
      end
      PH_SAMPLE: begin
        if (tick) begin
          if (cnt_q == SAMP_LAST) begin
            ph_n  = PH_CONVERT;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      PH_CONVERT: begin
        if (tick) begin
          if (cnt_q == CONV_LAST) begin
            res_valid = 1'b1;
            cnt_n     = '0;
            ph_n      = PH_SAMPLE;
            if (ch_q == CH_LAST) begin
              done = 1'b1;
              if (cont) ch_n = start_ch;
              else      ph_n = PH_IDLE;
            end else begin
              ch_n = ch_q + 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ch_q  <= '0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      ch_q  <= ch_n;
      cnt_q <= cnt_n;
    end
  end

  assign busy     = (ph_q != PH_IDLE);
  assign sampling = (ph_q == PH_SAMPLE);
  assign ch       = ch_q;
  assign res_data = conv_data;
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int RES_W  = 10,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic                    we,
  input  logic                    re,
  output logic [7:0]              rdata,
  input  logic                    busy,
  input  logic                    res_valid,
  input  logic [$clog2(NCH)-1:0]  res_ch,
  input  logic [RES_W-1:0]        res_data,
  input  logic                    done,
  output logic                    start,
  output logic [$clog2(NCH)-1:0]  start_ch,
  output logic [2:0]              clk_sel,
  output logic                    cont,
  output logic                    eoc_ie,
  output logic                    wd_ie,
  output logic                    eoc_flag,
  output logic [1:0]              wd_flag
);
  localparam int CH_W    = $clog2(NCH);
  localparam int LO_BITS = RES_W - 8;
  localparam logic [RES_W-1:0] THI_RST = '1;

  logic [CH_W-1:0]    first_q, wdb_q;
  logic [7:0]         run_q, run_n;
  logic [RES_W-1:0]   thi_q, thi_n, tlo_q, tlo_n;
  logic               eoc_n;
  logic [1:0]         wd_n, wd_hit;
  logic [7:0]         clr;
  logic [7:0]         rd_n;
  logic [LO_BITS-1:0] shad_q, shad_n;
  logic [RES_W-1:0]   res_q [NCH];
  logic [CH_W-1:0]    rd_ch;
  logic               wr_cfg, wr_run;

  assign wr_cfg  = we && (addr == A_SCANCFG);
  assign wr_run  = we && (addr == A_RUNCTL);
  assign clr     = (we && addr == A_FLAGS) ? wdata : 8'h00;
  assign start   = wr_run && wdata[0] && !busy;
  assign start_ch = first_q;
  assign clk_sel = run_q[7:5];
  assign eoc_ie  = run_q[4];
  assign wd_ie   = run_q[3];
  assign cont    = run_q[1];
  assign rd_ch   = addr[CH_W:1];

  // result storage, one register per channel
  for (genvar gi = 0; gi < NCH; gi++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   res_q[gi] <= '0;
      else if (res_valid && res_ch == CH_W'(gi))    res_q[gi] <= res_data;
    end
  end

  // window compare for the two watched slots
  for (genvar gk = 0; gk < 2; gk++) begin : g_wd
    logic [CH_W-1:0] wch;
    assign wch = wdb_q + CH_W'(gk);
    assign wd_hit[gk] = res_valid && (res_ch == wch) &&
                        ((res_data > thi_q) || (res_data < tlo_q));
  end

  always_comb begin
    run_n = run_q;
    if (wr_run) run_n = {wdata[7:3], 3'b000} | {6'b0, wdata[1], 1'b0};
    thi_n = thi_q;
    tlo_n = tlo_q;
    if (we && addr == A_THI_U) thi_n[RES_W-1 -: 8]   = wdata;
    if (we && addr == A_THI_L) thi_n[LO_BITS-1:0]    = wdata[7 -: LO_BITS];
    if (we && addr == A_TLO_U) tlo_n[RES_W-1 -: 8]   = wdata;
    if (we && addr == A_TLO_L) tlo_n[LO_BITS-1:0]    = wdata[7 -: LO_BITS];
    eoc_n = (eoc_flag & ~clr[0]) | done;
    wd_n  = (wd_flag & ~clr[2:1]) | wd_hit;
  end

  always_comb begin
    rd_n   = rdata;
    shad_n = shad_q;
    if (re) begin
      if (addr[ADDR_W-1]) begin
        if (!addr[0]) begin
          rd_n   = res_q[rd_ch][RES_W-1 -: 8];
          shad_n = res_q[rd_ch][LO_BITS-1:0];
        end else begin
          rd_n   = {shad_q, {(8-LO_BITS){1'b0}}};
        end
      end else begin
        case (addr)
          A_SCANCFG: rd_n = {first_q, wdb_q};
          A_RUNCTL:  rd_n = {run_q[7:2], cont, busy} & 8'hFB;
          A_FLAGS:   rd_n = {busy, 4'b0000, wd_flag, eoc_flag};
          A_THI_U:   rd_n = thi_q[RES_W-1 -: 8];
          A_THI_L:   rd_n = {thi_q[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
          A_TLO_U:   rd_n = tlo_q[RES_W-1 -: 8];
          A_TLO_L:   rd_n = {tlo_q[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
          default:   rd_n = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      wdb_q    <= '0;
      run_q    <= '0;
      thi_q    <= THI_RST;
      tlo_q    <= '0;
      eoc_flag <= 1'b0;
      wd_flag  <= '0;
      rdata    <= '0;
      shad_q   <= '0;
    end else begin
      if (wr_cfg) begin
        first_q <= wdata[7:4];
        wdb_q   <= wdata[3:0];
      end
      run_q    <= run_n;
      thi_q    <= thi_n;
      tlo_q    <= tlo_n;
      eoc_flag <= eoc_n;
      wd_flag  <= wd_n;
      rdata    <= rd_n;
      shad_q   <= shad_n;
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int RES_W    = 10,
  parameter int ADDR_W   = 6,
  parameter int SAMP_CYC = 8,
  parameter int CONV_CYC = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_we,
  input  logic                   bus_re,
  output logic [7:0]             bus_rdata,
  output logic [$clog2(NCH)-1:0] mux_sel,
  output logic                   sample_en,
  input  logic [RES_W-1:0]       conv_data,
  output logic                   irq
);
  localparam int CH_W = $clog2(NCH);

  logic [1:0]       rst_sq;
  logic             rst_sync_n;
  logic             adc_tick, busy, start, cont, eoc_ie, wd_ie, eoc_flag, done, res_valid;
  logic [1:0]       wd_flag;
  logic [2:0]       clk_sel;
  logic [CH_W-1:0]  start_ch, cur_ch;
  logic [RES_W-1:0] res_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sync_n = rst_sq[1];

  adcseq_clkdiv u_div (
    .clk(clk), .rst_n(rst_sync_n), .en(busy), .sel(clk_sel), .tick(adc_tick)
  );

  adcseq_scan #(.NCH(NCH), .RES_W(RES_W), .SAMP_CYC(SAMP_CYC), .CONV_CYC(CONV_CYC)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .tick(adc_tick), .start(start),
    .start_ch(start_ch), .cont(cont), .conv_data(conv_data), .busy(busy),
    .sampling(sample_en), .ch(cur_ch), .res_valid(res_valid),
    .res_data(res_data), .done(done)
  );

  adcseq_regs #(.NCH(NCH), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .rdata(bus_rdata), .busy(busy),
    .res_valid(res_valid), .res_ch(cur_ch), .res_data(res_data), .done(done),
    .start(start), .start_ch(start_ch), .clk_sel(clk_sel), .cont(cont),
    .eoc_ie(eoc_ie), .wd_ie(wd_ie), .eoc_flag(eoc_flag), .wd_flag(wd_flag)
  );

  assign mux_sel = cur_ch;
  assign irq     = (eoc_flag & eoc_ie) | ((|wd_flag) & wd_ie);
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CH_W   = 4,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              busy,
  input logic              sample_en,
  input logic [CH_W-1:0]   mux_sel,
  input logic              res_valid,
  input logic              eoc_flag,
  input logic [1:0]        wd_flag,
  input logic              irq,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata
);
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r3_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy);

  a_r3_mux_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(mux_sel));

  a_r9_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !(we && addr == ADDR_W'(2) && wdata[0])) |=> eoc_flag);

  a_r8_wd0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag[0]) |-> $past(res_valid));

  a_r8_wd1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag[1]) |-> $past(res_valid));

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_flag && wd_flag == 2'b00) |-> !irq);
endmodule

bind adcseq_top adcseq_chk #(.CH_W($clog2(NCH)), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(adc_tick), .busy(busy),
  .sample_en(sample_en), .mux_sel(mux_sel), .res_valid(res_valid),
  .eoc_flag(eoc_flag), .wd_flag(wd_flag), .irq(irq), .we(bus_we),
  .addr(bus_addr), .wdata(bus_wdata)
);

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
  localparam int CP = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic       we, re, sample_en, irq;
  logic [3:0] mux_sel;
  logic [9:0] conv_data;
  logic [9:0] mdl [16];
  logic       rd_pend;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CP/2) clk = ~clk;
  assign conv_data = mdl[mux_sel];

  adcseq_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .mux_sel(mux_sel),
    .sample_en(sample_en), .conv_data(conv_data), .irq(irq)
  );

  function automatic logic [7:0] up_b(input logic [9:0] v);
    return v[9:2];
  endfunction
  function automatic logic [7:0] lo_b(input logic [9:0] v);
    return {v[1:0], 6'b0};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares it
  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); re = 1'b0;
  endtask

  always @(posedge clk) rd_pend <= re;

  always @(negedge clk) begin
    if (rd_pend === 1'b1 && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  initial begin
    #(CP * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = 10'(i * 37);
    mdl[4] = 10'h3F0; mdl[5] = 10'h150; mdl[6] = 10'h3FF; mdl[7] = 10'h000;
    mdl[9] = 10'h2AD; mdl[14] = 10'h010; mdl[15] = 10'h101;
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({7'b0, irq}, 8'h00, "R1 irq");
    chk({7'b0, sample_en}, 8'h00, "R1 sample_en");
    rd(6'h00, 8'h00, "R1 scancfg");
    rd(6'h01, 8'h00, "R1 runctl");
    rd(6'h02, 8'h00, "R1 flags");
    rd(6'h04, 8'hFF, "R1 thi upper");
    rd(6'h05, 8'hC0, "R1 thi lower");
    rd(6'h06, 8'h00, "R1 tlo upper");
    rd(6'h07, 8'h00, "R1 tlo lower");
    rd(6'h20, 8'h00, "R1 result ch0");

    // R7 thresholds: high 0x203, low 0x081
    wr(6'h04, 8'h80); wr(6'h05, 8'hFF);
    wr(6'h06, 8'h20); wr(6'h07, 8'h40);
    rd(6'h04, 8'h80, "R7 thi upper");
    rd(6'h05, 8'hC0, "R7 thi lower masked");
    rd(6'h06, 8'h20, "R7 tlo upper");
    rd(6'h07, 8'h40, "R7 tlo lower");

    // scan 1: first ch 3, watch 5/6, divide by 4, end-of-scan irq on
    wr(6'h00, 8'h35);
    wr(6'h01, 8'h31);
    for (int k = 1; k <= 28 * 13 * 4; k++) begin
      @(posedge clk); #1;
      if (k == 1)   chk({4'b0, mux_sel}, 8'h03, "R4 first channel");
      if (k == 31)  chk({7'b0, sample_en}, 8'h01, "R3 sampling last tick");
      if (k == 32)  chk({7'b0, sample_en}, 8'h00, "R3 convert after 8 ticks");
      if (k == 111) chk({4'b0, mux_sel}, 8'h03, "R3 channel before 28 ticks");
      if (k == 112) chk({4'b0, mux_sel}, 8'h04, "R3 next channel at 28 ticks");
      if (k == 112) chk({7'b0, sample_en}, 8'h01, "R3 sampling next channel");
      if (k == 28 * 13 * 4 - 1) chk({7'b0, irq}, 8'h00, "R2 irq before end, div 4");
      if (k == 28 * 13 * 4)     chk({7'b0, irq}, 8'h01, "R4 R10 irq at end, div 4");
    end
    rd(6'h02, 8'h05, "R8 flags slot1 only, idle");
    rd(6'h20, 8'h00, "R4 ch0 untouched");
    rd(6'h24, 8'h00, "R4 ch2 untouched");
    for (int c = 3; c < 16; c++) begin
      rd(6'(6'h20 + 2 * c), up_b(mdl[c]), "R6 upper byte");
      rd(6'(6'h21 + 2 * c), lo_b(mdl[c]), "R6 lower byte");
    end
    rd(6'h2C, 8'hFF, "R6 full scale upper");
    rd(6'h2D, 8'hC0, "R6 full scale lower");
    rd(6'h2E, 8'h00, "R6 zero upper");

    // R9 write-one-to-clear
    wr(6'h02, 8'h04);
    rd(6'h02, 8'h01, "R9 clear wd bit keeps eoc");
    wr(6'h02, 8'h00);
    rd(6'h02, 8'h01, "R9 zero write no effect");
    wr(6'h02, 8'h01);
    rd(6'h02, 8'h00, "R9 eoc cleared");
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R10 irq low after clear");

    // scan 2: continuous, first 14, watch 14/15, divide by 2, wd irq only
    wr(6'h00, 8'hEE);
    wr(6'h01, 8'h0B);
    repeat (150) @(negedge clk);
    rd(6'h02, 8'h83, "R5 busy after first pass, R8 low side");
    chk({7'b0, irq}, 8'h01, "R10 watchdog irq");
    wr(6'h01, 8'h08);
    repeat (300) @(negedge clk);
    rd(6'h02, 8'h03, "R5 stopped after clearing continuous");
    rd(6'h01, 8'h08, "R5 runctl idle");
    wr(6'h02, 8'h02);
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R10 eoc without enable");

    // R11 split read across a reconversion
    rd(6'h3E, up_b(10'h101), "R11 upper before reconversion");
    mdl[15] = 10'h2AE;
    wr(6'h02, 8'h07);
    wr(6'h00, 8'hFE);
    wr(6'h01, 8'h11);
    for (int k = 1; k <= 56; k++) begin
      @(posedge clk); #1;
      if (k == 55) chk({7'b0, irq}, 8'h00, "R2 irq before end, div 2");
      if (k == 56) chk({7'b0, irq}, 8'h01, "R2 irq at end, div 2");
    end
    rd(6'h3F, lo_b(10'h101), "R11 lower keeps captured bits");
    rd(6'h3E, 8'hAB, "R11 new upper");
    rd(6'h3F, 8'h80, "R11 new lower");

    // divide by 32, single channel 15
    wr(6'h02, 8'h07);
    wr(6'h01, 8'hF1);
    for (int k = 1; k <= 28 * 32; k++) begin
      @(posedge clk); #1;
      if (k == 28 * 32 - 1) chk({7'b0, irq}, 8'h00, "R2 irq before end, div 32");
      if (k == 28 * 32)     chk({7'b0, irq}, 8'h01, "R2 irq at end, div 32");
    end
    rd(6'h02, 8'h05, "R4 busy clear after single scan");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule